// File: doc/BRIEF.md
# Time-Sliced Pixel Hit Cell

This block is the digital part of one photon-counting pixel. It sits behind the pixel's discriminator and counts photon hits in fixed time slices. A slice strobe marks the end of each slice. The cell keeps collecting hits in the slice that is running while the count from the previous slice waits to be read, so acquisition never stops.

Two hit counters share the work. One counts the running slice (the waiting stage) and the other holds the finished slice (the service stage). The counters trade places at a slice strobe only if at least one hit was recorded during the slice that just ended; an empty slice leaves everything untouched, which saves switching.

A pixel that holds data raises a request towards the group's priority encoder. When the encoder selects the pixel, the cell drives its service count onto the shared count bus, and an acknowledge then retires the request. Two configuration bits control each pixel: a kill bit silences it, and a set bit forces it to request every cycle, as imaging readout needs. Kill wins over set.

Top module: `slot_pixel_cell`

## Requirements
- R1: The discriminator level passes through a synchroniser of SYNC_STAGES flops. Each rising edge of the synchronised level adds exactly one to the counting counter, however long the level stays high.
- R2: A slice strobe that ends a slice containing at least one hit swaps the counters. The finished count becomes the service count, request is raised, and the counter that used to be the service counter is cleared (unread data in it is replaced). The new counting counter starts at zero.
- R3: A slice strobe that ends a slice with no hit leaves the roles, the service count and the request state unchanged.
- R4: The counting counter saturates at 2^CNT_W-1 (31 for the default 5 bits) and never wraps.
- R5: An acknowledge clears the pending request and sets the service count to zero. If an acknowledge and a swapping strobe fall in the same cycle, the swap wins and the request stays raised for the new data.
- R6: A pulse that is still high at a slice strobe counts once, in the slice where its rising edge was seen. It adds nothing to the next slice, even if it ends there.
- R7: While kill is high, no hit is counted and no swap is caused by the discriminator, and kill overrides set on the request.
- R8: While set is high and kill is low, request is high whatever the service state, including after an acknowledge.
- R9: The count output carries the service count while the pixel is selected and is all zeros otherwise.
- R10: After reset, request is low, both counts are zero and no slice has a hit recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disc_i | input | 1 | Discriminator level, asynchronous to clk |
| slice_tick_i | input | 1 | One-cycle strobe ending the current time slice |
| cfg_set_i | input | 1 | Force the pixel to request every cycle |
| cfg_kill_i | input | 1 | Disable hit counting; overrides set |
| rd_sel_i | input | 1 | Pixel is selected by the readout encoder |
| rd_ack_i | input | 1 | Readout acknowledge strobe |
| req_o | output | 1 | Readout request to the group encoder |
| cnt_o | output | CNT_W | Service count while selected, zero otherwise |

## Verification
The bench sweeps the number of pulses per slice from 0 to 33 and checks the service count after each strobe. A design that wraps would report a small value in place of 31, and a design that swaps on an empty slice would raise a request with count zero. One pulse is held high across a strobe and released in the next slice. A design that re-arms its edge detector at the strobe counts that pulse a second time and swaps again. The bench also lets an unread count sit through an empty slice and checks that it survives, then checks that it is replaced once a slice with hits arrives. Finally it walks the kill and set combinations and toggles the select line, which exposes a wrong kill/set priority or a count bus that is not blanked when the pixel is deselected.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
   // Role of a counter in the ping-pong pair
   typedef enum logic {
      ROLE_ACC = 1'b0,   // counting the running slice
      ROLE_SVC = 1'b1    // holding the finished slice for readout
   } role_e;

   localparam int unsigned MIN_SYNC = 2;
   localparam int unsigned MAX_CNT_W = 16;
endpackage

// File: rtl/pxc_sync.sv
module pxc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < pxc_pkg::MIN_SYNC) begin : g_bad_stages
         $error("pxc_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pxc_hit_gate.sv
module pxc_hit_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic mask_i,
   output logic hit_o
);
   // used_q remembers that the current high level was already seen.
   // The slice strobe does not touch it, so a pulse that spans a
   // boundary must drop low before another hit can count.
   logic used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) used_q <= 1'b0;
      else        used_q <= lvl_i;
   end

   assign hit_o = lvl_i & ~used_q & ~mask_i;

   AST_ONE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o) else $error("hit on consecutive cycles");   // R1
   AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i && used_q) |-> !hit_o) else $error("held level counted again");   // R6
endmodule

// File: rtl/pxc_pingpong.sv
module pxc_pingpong #(
   parameter int unsigned CNT_W    = 5,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             tick_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] svc_cnt_o,
   output logic [CNT_W-1:0] acc_cnt_o,
   output logic             pend_o,
   output logic             swap_o
);
   import pxc_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int unsigned      N_CNT   = 2;

   generate
      if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("pxc_pingpong: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q [N_CNT];
   logic [CNT_W-1:0] cnt_n [N_CNT];
   logic             wr_q;     // index of the counter that is counting
   logic             seen_q;   // a hit was recorded in the running slice
   logic             pend_q;
   logic             swap;
   logic [CNT_W-1:0] step_val;

   assign swap = tick_i & (seen_q | hit_i);

   // Increment of the counting counter: saturating or wrapping variant
   generate
      if (SATURATE) begin : g_sat
         assign step_val = (cnt_q[wr_q] == CNT_MAX) ? CNT_MAX : cnt_q[wr_q] + 1'b1;
      end else begin : g_wrap
         assign step_val = cnt_q[wr_q] + 1'b1;
      end
   endgenerate

   generate
      for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
         logic is_acc;
         assign is_acc = (wr_q == 1'(i));

         always_comb begin
            if (is_acc) begin
               cnt_n[i] = hit_i ? step_val : cnt_q[i];
            end else if (swap || ack_i) begin
               cnt_n[i] = '0;
            end else begin
               cnt_n[i] = cnt_q[i];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_n[i];
         end

         AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (SATURATE && is_acc && cnt_q[i] == CNT_MAX) |=> cnt_q[i] == CNT_MAX)
            else $error("counter left its ceiling");   // R4
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= ROLE_ACC;
         seen_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (swap) wr_q <= ~wr_q;
         seen_q <= tick_i ? 1'b0 : (seen_q | hit_i);
         if (swap)       pend_q <= 1'b1;
         else if (ack_i) pend_q <= 1'b0;
      end
   end

   assign svc_cnt_o = cnt_q[~wr_q];
   assign acc_cnt_o = cnt_q[wr_q];
   assign pend_o    = pend_q;
   assign swap_o    = swap;

   AST_NO_SWAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !seen_q && !hit_i) |=> ($stable(wr_q) && $stable(svc_cnt_o)))
      else $error("roles changed on an empty slice");   // R3
   AST_SWAP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (pend_q && acc_cnt_o == '0))
      else $error("swap did not present fresh data");   // R2
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !swap) |=> (!pend_q && svc_cnt_o == '0))
      else $error("acknowledge left data behind");   // R5
endmodule

// File: rtl/slot_pixel_cell.sv
module slot_pixel_cell #(
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disc_i,
   input  logic             slice_tick_i,
   input  logic             cfg_set_i,
   input  logic             cfg_kill_i,
   input  logic             rd_sel_i,
   input  logic             rd_ack_i,
   output logic             req_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic             disc_lvl;
   logic             hit;
   logic             pend;
   logic             swap;
   logic [CNT_W-1:0] svc_cnt;
   logic [CNT_W-1:0] acc_cnt;

   pxc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (disc_i),
      .q_o   (disc_lvl)
   );

   pxc_hit_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (disc_lvl),
      .mask_i (cfg_kill_i),
      .hit_o  (hit)
   );

   pxc_pingpong #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (hit),
      .tick_i    (slice_tick_i),
      .ack_i     (rd_ack_i),
      .svc_cnt_o (svc_cnt),
      .acc_cnt_o (acc_cnt),
      .pend_o    (pend),
      .swap_o    (swap)
   );

   assign req_o = pend | (cfg_set_i & ~cfg_kill_i);
   assign cnt_o = rd_sel_i ? svc_cnt : '0;

   AST_KILL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_kill_i && !slice_tick_i) |=> $stable(acc_cnt))
      else $error("killed pixel counted");   // R7
   AST_KILL_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_kill_i && !slice_tick_i) |=> !swap)
      else $error("killed pixel swapped");   // R7
   AST_DESEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_sel_i |-> cnt_o == '0) else $error("bus not blanked");   // R9
endmodule

// File: tb/sim_slot_pixel_cell.sv
module sim_slot_pixel_cell;
   localparam int unsigned W = 5;
   localparam int unsigned MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic disc = 1'b0, tick = 1'b0, set_b = 1'b0, kill_b = 1'b0;
   logic sel = 1'b1, ack = 1'b0;
   logic req;
   logic [W-1:0] cnt;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   slot_pixel_cell #(.CNT_W(W), .SYNC_STAGES(2), .SATURATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .disc_i(disc), .slice_tick_i(tick),
      .cfg_set_i(set_b), .cfg_kill_i(kill_b), .rd_sel_i(sel), .rd_ack_i(ack),
      .req_o(req), .cnt_o(cnt));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulses(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) disc = 1'b1;
         repeat (3) @(negedge clk);
         disc = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic strobe_slice();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_ack();
      @(negedge clk) ack = 1'b1;
      @(negedge clk) ack = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk("R10 req after reset", int'(req), 0);
      chk("R10 count after reset", int'(cnt), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 req idle", int'(req), 0);

      // Sweep of hits per slice: R1 R2 R3 R4 R5
      for (int n = 0; n <= 33; n++) begin
         pulses(n);
         strobe_slice();
         if (n == 0) begin
            chk("R3 empty slice req", int'(req), 0);
            chk("R3 empty slice count", int'(cnt), 0);
         end else begin
            chk("R2 req after swap", int'(req), 1);
            chk((n > MAXV) ? "R4 saturated count" : "R1 slice count",
                int'(cnt), (n > MAXV) ? MAXV : n);
         end
         do_ack();
         chk("R5 req after ack", int'(req), 0);
         chk("R5 count after ack", int'(cnt), 0);
      end

      // Unread data survives an empty slice, then is replaced (R3, R2)
      pulses(4);
      strobe_slice();
      strobe_slice();
      chk("R3 retained req", int'(req), 1);
      chk("R3 retained count", int'(cnt), 4);
      pulses(2);
      strobe_slice();
      chk("R2 replaced count", int'(cnt), 2);
      chk("R2 replaced req", int'(req), 1);
      do_ack();

      // Pulse spanning a boundary counts once (R6)
      @(negedge clk) disc = 1'b1;
      repeat (6) @(negedge clk);
      strobe_slice();
      chk("R6 spanning pulse in old slice", int'(cnt), 1);
      do_ack();
      repeat (4) @(negedge clk);
      disc = 1'b0;
      repeat (6) @(negedge clk);
      strobe_slice();
      chk("R6 no recount req", int'(req), 0);
      chk("R6 no recount count", int'(cnt), 0);

      // Select blanking (R9)
      pulses(3);
      strobe_slice();
      sel = 1'b0;
      @(negedge clk);
      chk("R9 deselected count", int'(cnt), 0);
      chk("R9 deselected req", int'(req), 1);
      sel = 1'b1;
      @(negedge clk);
      chk("R9 selected count", int'(cnt), 3);
      do_ack();

      // Kill and set (R7, R8)
      kill_b = 1'b1;
      pulses(5);
      strobe_slice();
      chk("R7 killed req", int'(req), 0);
      chk("R7 killed count", int'(cnt), 0);
      set_b = 1'b1;
      @(negedge clk);
      chk("R7 kill over set", int'(req), 0);
      kill_b = 1'b0;
      @(negedge clk);
      chk("R8 set forces req", int'(req), 1);
      chk("R8 set count zero", int'(cnt), 0);
      do_ack();
      chk("R8 set req after ack", int'(req), 1);
      set_b = 1'b0;
      @(negedge clk);
      chk("R8 req released", int'(req), 0);
      pulses(2);
      strobe_slice();
      chk("R7 counting after unkill", int'(cnt), 2);
      do_ack();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule